// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block sits between a processor core and a shared word memory and lets software build atomic read-modify-write sequences without locking the bus. The core issues one request per cycle on its request port: a plain load, a plain store, a linked load or a conditional store. A linked load reads the addressed word and arms a single reservation on that word. A conditional store writes memory only while that reservation is still armed for the same word. Instead of write data, it answers the core with 1 on success or 0 on failure. The reservation is dropped after every conditional store, whatever its outcome.

Other bus masters report their writes on an external-write input. Any such write, and any plain store from the core, that touches any byte of the reserved word disarms the reservation. If an external write and a conditional store to the same word arrive in the same cycle, the external write takes precedence and the conditional store fails. The memory port is a simple single-cycle request interface, and read data returns on the cycle after the request. Every core request gets exactly one response, one cycle after it is issued.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is pending (`rsp_valid_o` low) and no reservation is held, so a conditional store issued first fails.
- R2: A linked load (op code 2) drives a memory read, and one cycle later returns the addressed word with `rsp_valid_o` high.
- R3: A conditional store (op code 3) to the reserved word, issued while the reservation is still armed, drives a memory write with its byte enables and returns 1 one cycle later.
- R4: A failing conditional store drives no memory write (`mem_we_o` low), leaves memory unchanged and returns 0.
- R5: Every conditional store disarms the reservation, so a second conditional store with no new linked load in between fails.
- R6: An external write to any byte address inside the reserved word (word = address bits above the byte offset) disarms the reservation.
- R7: A plain core store (op code 1) to any byte of the reserved word disarms the reservation.
- R8: A conditional store to a word other than the reserved one fails.
- R9: A new linked load replaces any older reservation with its own word.
- R10: An external write and a conditional store to the same word in the same cycle make the conditional store fail.
- R11: An external write to the same word in the same cycle as a linked load leaves no reservation armed.
- R12: External writes and plain stores to other words leave the reservation armed.
- R13: A plain load (op code 0) returns the addressed word one cycle later. A plain store writes the enabled bytes and returns 0. Neither affects the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request present this cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_wdata_i | input | DATA_W | Store data |
| req_be_i | input | DATA_W/8 | Byte enables for stores |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_data_o | output | DATA_W | Read word, or conditional-store result (1/0), or 0 for stores |
| ext_wr_valid_i | input | 1 | Another agent writes shared memory this cycle |
| ext_wr_addr_i | input | ADDR_W | Byte address of that external write |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_be_o | output | DATA_W/8 | Memory byte enables |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the read request |

## Verification
The bench builds the block with an 8-bit address and a 32-bit word, so the shared memory has only 64 words and a bench array models it completely. With this size, random traffic limited to four neighbouring words hits the reserved word often. That random traffic covers linked loads, stores and external writes at every byte offset, including collisions in the same cycle. The directed steps then cover each case of disarming, replacement and same-cycle priority one at a time.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_ld_link_i,
  input  logic              core_st_cond_i,
  input  logic              core_st_plain_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic              ext_wr_valid_i,
  input  logic [ADDR_W-1:0] ext_wr_addr_i,
  output logic              sc_pass_o
);
  localparam int WA_W = ADDR_W - OFS_W;

  logic            armed_q, armed_d;
  logic [WA_W-1:0] word_q, word_d;
  logic [WA_W-1:0] core_word, ext_word;
  logic            link_live, ext_hits_core, ext_hits_resv;

  assign core_word     = WA_W'(core_addr_i >> OFS_W);
  assign ext_word      = WA_W'(ext_wr_addr_i >> OFS_W);
  assign link_live     = armed_q && (word_q == core_word);
  assign ext_hits_core = ext_wr_valid_i && (ext_word == core_word);
  assign ext_hits_resv = ext_wr_valid_i && (ext_word == word_q);

  // external write to the same word in the same cycle wins
  assign sc_pass_o = core_st_cond_i && link_live && !ext_hits_core;

  always_comb begin
    armed_d = armed_q;
    word_d  = word_q;
    if (ext_hits_resv) armed_d = 1'b0;
    if (core_st_plain_i && link_live) armed_d = 1'b0;
    if (core_st_cond_i) armed_d = 1'b0;
    if (core_ld_link_i) begin
      armed_d = !ext_hits_core;
      word_d  = core_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      word_q  <= '0;
    end else begin
      armed_q <= armed_d;
      word_q  <= word_d;
    end
  end
endmodule

// File: rtl/llsc_mem_drv.sv
module llsc_mem_drv #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  req_valid_i,
  input  logic                  is_store_i,
  input  logic                  sc_pass_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [DATA_W/8-1:0]   req_be_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic [DATA_W/8-1:0]   mem_be_o
);
  assign mem_req_o   = req_valid_i;
  assign mem_we_o    = req_valid_i && (is_store_i || sc_pass_i);
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;
  assign mem_be_o    = req_be_i;
endmodule

// File: rtl/llsc_rsp.sv
module llsc_rsp
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  llsc_op_e          req_op_i,
  input  logic              sc_pass_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic     valid_q, ok_q;
  llsc_op_e op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      op_q    <= OP_LOAD;
      ok_q    <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      op_q    <= req_op_i;
      ok_q    <= sc_pass_i;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_SC:    rsp_data_o = {{(DATA_W-1){1'b0}}, ok_q};
      OP_STORE: rsp_data_o = '0;
      default:  rsp_data_o = mem_rdata_i;
    endcase
  end

  assign rsp_valid_o = valid_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_op_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  input  logic                ext_wr_valid_i,
  input  logic [ADDR_W-1:0]   ext_wr_addr_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  llsc_op_e op;
  logic     is_ll, is_sc, is_st, sc_pass;

  assign op    = llsc_op_e'(req_op_i);
  assign is_ll = req_valid_i && (op == OP_LL);
  assign is_sc = req_valid_i && (op == OP_SC);
  assign is_st = req_valid_i && (op == OP_STORE);

  llsc_resv #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_resv (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .core_ld_link_i (is_ll),
    .core_st_cond_i (is_sc),
    .core_st_plain_i(is_st),
    .core_addr_i    (req_addr_i),
    .ext_wr_valid_i (ext_wr_valid_i),
    .ext_wr_addr_i  (ext_wr_addr_i),
    .sc_pass_o      (sc_pass)
  );

  llsc_mem_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem_drv (
    .req_valid_i(req_valid_i),
    .is_store_i (is_st),
    .sc_pass_i  (sc_pass),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_be_i   (req_be_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_be_o   (mem_be_o)
  );

  llsc_rsp #(.DATA_W(DATA_W)) i_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (op),
    .sc_pass_i  (sc_pass),
    .mem_rdata_i(mem_rdata_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_data_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              ext_wr_valid_i,
  input logic [ADDR_W-1:0] ext_wr_addr_i,
  input logic              mem_we_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o
);
  localparam int OFS_W = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 1;

  logic sc_now, rd_now, same_word;
  assign sc_now    = req_valid_i && (req_op_i == 2'd3);
  assign rd_now    = req_valid_i && (req_op_i[0] == 1'b0);
  assign same_word = (ext_wr_addr_i >> OFS_W) == (req_addr_i >> OFS_W);

  p_rsp_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_sc_ok_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_now && mem_we_o) |=> (rsp_data_o == DATA_W'(1)));
  p_sc_fail_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_now && !mem_we_o) |=> (rsp_data_o == '0));
  p_sc_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_now ##1 sc_now |-> !mem_we_o);
  p_ext_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_now && ext_wr_valid_i && same_word) |-> !mem_we_o);
  p_reads_no_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_now |-> !mem_we_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_op_i      (req_op_i),
  .req_addr_i    (req_addr_i),
  .ext_wr_valid_i(ext_wr_valid_i),
  .ext_wr_addr_i (ext_wr_addr_i),
  .mem_we_o      (mem_we_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_data_o    (rsp_data_o)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0]    req_be = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          ext_v = 1'b0;
  logic [AW-1:0] ext_a = '0;
  logic [DW-1:0] ext_d = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [3:0]    mem_be;

  logic [DW-1:0] shmem [64];
  logic [DW-1:0] ref_mem [64];
  bit            ref_armed;
  logic [5:0]    ref_word;
  int            n_run, n_fail;
  bit            done;

  always #10 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .ext_wr_valid_i(ext_v), .ext_wr_addr_i(ext_a),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata)
  );

  // shared memory: core access first, external agent write last
  always_ff @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) shmem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else if (mem_req) begin
      mem_rdata <= shmem[mem_addr[7:2]];
    end
    if (ext_v) shmem[ext_a[7:2]] <= ext_d;
  end

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one request cycle, driven at the falling edge, response checked one cycle later
  task automatic step(input string tag, input bit v, input logic [1:0] op,
                      input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                      input bit sv, input logic [7:0] sa, input logic [31:0] sd);
    bit live, shit, pass, exp_we;
    logic [31:0] exp_rd;
    logic [5:0] wa;
    req_valid = v; req_op = op; req_addr = a; req_wdata = d; req_be = be;
    ext_v = sv; ext_a = sa; ext_d = sd;
    #1;
    wa     = a[7:2];
    live   = ref_armed && (ref_word == wa);
    shit   = sv && (sa[7:2] == wa);
    pass   = v && (op == 2'd3) && live && !shit;
    exp_we = v && ((op == 2'd1) || pass);
    check(tag, "mem_we", {31'b0, mem_we}, {31'b0, exp_we});
    exp_rd = (op == 2'd3) ? {31'b0, pass} : (op == 2'd1) ? 32'h0 : ref_mem[wa];
    if (exp_we)
      for (int b = 0; b < 4; b++) if (be[b]) ref_mem[wa][8*b +: 8] = d[8*b +: 8];
    if (sv) ref_mem[sa[7:2]] = sd;
    if (sv && ref_armed && (sa[7:2] == ref_word)) ref_armed = 0;
    if (v) begin
      case (op)
        2'd1: if (live) ref_armed = 0;
        2'd2: begin ref_armed = !shit; ref_word = wa; end
        2'd3: ref_armed = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ext_v = 1'b0;
    check(tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, v});
    if (v) check(tag, "rsp_data", rsp_data, exp_rd);
  endtask

  task automatic ld(input string t, input logic [7:0] a);
    step(t, 1, 2'd0, a, 0, 4'h0, 0, 0, 0);
  endtask
  task automatic st(input string t, input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    step(t, 1, 2'd1, a, d, be, 0, 0, 0);
  endtask
  task automatic ll(input string t, input logic [7:0] a);
    step(t, 1, 2'd2, a, 0, 4'h0, 0, 0, 0);
  endtask
  task automatic sc(input string t, input logic [7:0] a, input logic [31:0] d);
    step(t, 1, 2'd3, a, d, 4'hF, 0, 0, 0);
  endtask
  task automatic ext(input string t, input logic [7:0] a, input logic [31:0] d);
    step(t, 0, 2'd0, 0, 0, 4'h0, 1, a, d);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      shmem[i]   = (i * 32'h01010101) ^ 32'hA5000000;
      ref_mem[i] = (i * 32'h01010101) ^ 32'hA5000000;
    end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    sc("R1", 8'h20, 32'h11111111);           // no reservation yet
    ld("R4", 8'h20);
    ld("R13", 8'h10);
    st("R13", 8'h14, 32'hDEADBEEF, 4'b0011);
    ld("R13", 8'h14);
    ll("R2", 8'h20);
    sc("R3", 8'h20, 32'hCAFEF00D);
    ld("R3", 8'h20);
    sc("R5", 8'h20, 32'h12345678);
    ld("R4", 8'h20);
    ll("R6", 8'h24); ext("R6", 8'h27, 32'h0BADCAFE); sc("R6", 8'h24, 32'h1);
    ld("R6", 8'h24);
    ll("R7", 8'h28); st("R7", 8'h2A, 32'h00550000, 4'b0100); sc("R7", 8'h28, 32'h2);
    ll("R8", 8'h30); sc("R8", 8'h34, 32'h3); sc("R5", 8'h30, 32'h4);
    ll("R9", 8'h38); ll("R9", 8'h3C); sc("R9", 8'h38, 32'h5);
    ll("R9", 8'h38); ll("R9", 8'h3C); sc("R9", 8'h3C, 32'h6);
    ll("R10", 8'h40);
    step("R10", 1, 2'd3, 8'h40, 32'h7, 4'hF, 1, 8'h41, 32'h77777777);
    ld("R10", 8'h40);
    step("R11", 1, 2'd2, 8'h44, 0, 4'h0, 1, 8'h46, 32'h88888888);
    sc("R11", 8'h44, 32'h8);
    ll("R12", 8'h48); ext("R12", 8'h50, 32'h99); st("R12", 8'h4C, 32'hAA, 4'hF);
    ld("R13", 8'h48); sc("R12", 8'h48, 32'h9);
    for (int i = 0; i < 400; i++) begin
      step("R3", 1'($urandom_range(0, 3) != 0), 2'($urandom), 8'h80 | 8'($urandom_range(0, 15)),
           $urandom, 4'($urandom), 1'($urandom_range(0, 4) == 0),
           8'h80 | 8'($urandom_range(0, 15)), $urandom);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule